// File: doc/BRIEF.md
# 128-bit SIMD Compare and Logic Unit

This block is an integer execution unit that works on two 128-bit operands in parallel lanes of 8, 16 or 32 bits. It adds, applies bitwise logic, shifts and rotates halfwords, and compares lanes. The unit has no condition flags. A compare writes a mask into every lane: all ones if the condition holds and all zeros if it does not. Later code can use that mask directly as a select or as a branch value.

A small evaluator sits next to the lane datapath and looks only at the leftmost 32-bit word of each operand, called the scalar slot. A branch-if-nonzero operation pulses a taken signal when the scalar slot of A is nonzero. A halt-if-greater operation compares the scalar slots of A and B as signed numbers. If A is greater, the unit enters a sticky halted state that blocks every later write until reset. The halt is imprecise: operations already accepted still complete, and operations that arrive later are dropped.

Each operation is presented for one cycle with `in_valid`. The result register and its valid flag update on the next clock edge.

Top module: `simd_cmp_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid`, `out_taken` and `halted` are 0 and `out_result` is all zeros.
- R2: A result-writing operation (codes 0 to 11) accepted with `in_valid` high produces `out_result` with `out_valid` high one clock later. In every other cycle `out_valid` is 0 and `out_result` keeps its last value. Codes 12 to 15 never write a result.
- R3: Add (code 0) adds each lane modulo 2^lane width, with no carry between lanes. The lane code is 0 for byte, 1 for halfword, 2 for word, and 3 is treated as word.
- R4: Logic codes 1 AND, 2 OR, 3 XOR, 4 NAND, 5 NOR and 6 equivalence (XNOR) act bit by bit, and the lane code has no effect on them.
- R5: Halfword shift left (code 7) shifts each 16-bit lane of A by the low 5 bits of the matching lane of B. A count of 16 to 31 gives 0.
- R6: Halfword rotate left (code 8) rotates each 16-bit lane of A by the matching lane of B modulo 16.
- R7: Compare equal (code 9) sets each lane to all ones when the A and B lanes are equal, and to all zeros otherwise.
- R8: Compare greater (code 10) treats halfword and word lanes as signed and byte lanes as unsigned, and sets each lane to an all-ones or all-zeros mask.
- R9: Logical compare greater (code 11) treats lanes of every width as unsigned, and sets each lane to an all-ones or all-zeros mask.
- R10: Branch-if-nonzero (code 12) tests the scalar slot `in_a[127:96]`, where byte 0 is `in_a[127:120]`. If that word is nonzero, `out_taken` is 1 for exactly the next cycle. No result is written.
- R11: Halt-if-greater (code 13) compares `in_a[127:96]` with `in_b[127:96]` as signed numbers. If A is greater, `halted` becomes 1 on the next cycle. No result is written.
- R12: Once `halted` is 1 it stays 1 until reset. While it is 1, `out_valid` and `out_taken` stay 0 and `out_result` is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code |
| in_lane | input | 2 | Lane width code for add and compares |
| in_a | input | 128 | First operand |
| in_b | input | 128 | Second operand or per-lane counts |
| out_valid | output | 1 | Result written this cycle |
| out_result | output | 128 | Registered result |
| out_taken | output | 1 | Branch taken pulse |
| halted | output | 1 | Sticky halt state |

## Verification
The checker enforces on every cycle that the halt state is sticky and blocks all writes and branch pulses. It also enforces that the result changes only together with `out_valid`, that a taken pulse or a halt entry can only come from the matching operation, and that every word compare produces whole-lane masks. Correct arithmetic cannot be shown by those properties. Directed scenarios are needed for the per-lane wrap at each width, the signed and unsigned ordering of compares, the count edges of the shift and rotate, and the scalar-slot selection of branch and halt.

// File: rtl/simd_cmp_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and codes for the SIMD compare/logic unit.
// Assumes a 128-bit datapath and a 32-bit scalar slot at the top of the operand.
package simd_cmp_pkg;
    localparam int DATA_W  = 128;
    localparam int PSLOT_W = 32;
    localparam int OP_W    = 4;
    localparam int LANE_CW = 2;
    localparam int HALF_W  = 16;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_AND  = 4'd1,
        OP_OR   = 4'd2,
        OP_XOR  = 4'd3,
        OP_NAND = 4'd4,
        OP_NOR  = 4'd5,
        OP_EQV  = 4'd6,
        OP_SHLH = 4'd7,
        OP_ROTH = 4'd8,
        OP_CEQ  = 4'd9,
        OP_CGT  = 4'd10,
        OP_CLGT = 4'd11,
        OP_BRNZ = 4'd12,
        OP_HGT  = 4'd13
    } op_e;

    typedef enum logic [LANE_CW-1:0] {
        LN_BYTE = 2'd0,
        LN_HALF = 2'd1,
        LN_WORD = 2'd2
    } lane_e;
endpackage

// File: rtl/simd_lane_slice.sv
`timescale 1ns/1ps
// Module: simd_lane_slice
// Splits both operands into lanes of LANE_BITS and computes, per lane, the
// wrapping sum and the equal / greater / unsigned-greater masks.
// Assumes DATA_W is a multiple of LANE_BITS. SIGNED_GT picks the signedness of gt_mask.
module simd_lane_slice #(
    parameter int DATA_W    = 128,
    parameter int LANE_BITS = 8,
    parameter bit SIGNED_GT = 1'b1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] eq_mask,
    output logic [DATA_W-1:0] gt_mask,
    output logic [DATA_W-1:0] gtu_mask
);
    localparam int N_LANES = DATA_W / LANE_BITS;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [LANE_BITS-1:0] la;
        logic [LANE_BITS-1:0] lb;
        assign la = a[i*LANE_BITS +: LANE_BITS];
        assign lb = b[i*LANE_BITS +: LANE_BITS];
        // lane sum wraps at the lane width, so no carry leaves the lane
        assign sum[i*LANE_BITS +: LANE_BITS]      = la + lb;
        assign eq_mask[i*LANE_BITS +: LANE_BITS]  = {LANE_BITS{la == lb}};
        assign gtu_mask[i*LANE_BITS +: LANE_BITS] = {LANE_BITS{la > lb}};
        if (SIGNED_GT) begin : g_signed
            assign gt_mask[i*LANE_BITS +: LANE_BITS] = {LANE_BITS{$signed(la) > $signed(lb)}};
        end else begin : g_unsigned
            assign gt_mask[i*LANE_BITS +: LANE_BITS] = {LANE_BITS{la > lb}};
        end
    end
endmodule

// File: rtl/simd_hw_shifter.sv
`timescale 1ns/1ps
// Module: simd_hw_shifter
// Shift-left and rotate-left of every HW-bit lane by its own count.
// Assumes HW is a power of two. cnt holds CNT_W bits per lane, so a count of
// HW or more is marked by the top count bit.
module simd_hw_shifter #(
    parameter int DATA_W = 128,
    parameter int HW     = 16,
    localparam int N_LANES = DATA_W / HW,
    localparam int ROT_W   = $clog2(HW),
    localparam int CNT_W   = ROT_W + 1
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [N_LANES*CNT_W-1:0] cnt,
    output logic [DATA_W-1:0]        shl,
    output logic [DATA_W-1:0]        rot
);
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [HW-1:0]    la;
        logic [CNT_W-1:0] sc;
        logic [2*HW-1:0]  dbl;
        assign la  = a[i*HW +: HW];
        assign sc  = cnt[i*CNT_W +: CNT_W];
        // doubled lane shifted left: its upper half is the rotated lane
        assign dbl = {la, la} << sc[ROT_W-1:0];
        assign shl[i*HW +: HW] = sc[CNT_W-1] ? '0 : (la << sc[ROT_W-1:0]);
        assign rot[i*HW +: HW] = dbl[2*HW-1 -: HW];
    end
endmodule

// File: rtl/simd_pslot_eval.sv
`timescale 1ns/1ps
// Module: simd_pslot_eval
// Tests the scalar-slot words: nonzero test for branch, signed greater for halt.
// Assumes the caller has already taken the slots out of the full operands.
module simd_pslot_eval #(
    parameter int PSLOT_W = 32
) (
    input  logic [PSLOT_W-1:0] slot_a,
    input  logic [PSLOT_W-1:0] slot_b,
    output logic               nonzero,
    output logic               a_gt_b
);
    assign nonzero = |slot_a;
    assign a_gt_b  = $signed(slot_a) > $signed(slot_b);
endmodule

// File: rtl/simd_cmp_unit.sv
`timescale 1ns/1ps
// Module: simd_cmp_unit (top)
// One-stage SIMD integer unit: add, logic, halfword shift/rotate, and lane
// compares that write masks. Scalar-slot branch test and a sticky halt.
// Assumes one operation per cycle at most and synchronous active-low reset.
module simd_cmp_unit
    import simd_cmp_pkg::*;
#(
    parameter int D_W  = simd_cmp_pkg::DATA_W,
    parameter int PS_W = simd_cmp_pkg::PSLOT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     in_op,
    input  logic [LANE_CW-1:0]  in_lane,
    input  logic [D_W-1:0]      in_a,
    input  logic [D_W-1:0]      in_b,
    output logic                out_valid,
    output logic [D_W-1:0]      out_result,
    output logic                out_taken,
    output logic                halted
);
    localparam int N_WIDTHS = 3;
    localparam int N_HALF   = D_W / HALF_W;
    localparam int CNT_W    = $clog2(HALF_W) + 1;

    logic [D_W-1:0] sum_v [N_WIDTHS];
    logic [D_W-1:0] eq_v  [N_WIDTHS];
    logic [D_W-1:0] gt_v  [N_WIDTHS];
    logic [D_W-1:0] gtu_v [N_WIDTHS];

    // byte, halfword and word lane slices; only byte compares are unsigned
    for (genvar w = 0; w < N_WIDTHS; w++) begin : g_width
        simd_lane_slice #(
            .DATA_W    (D_W),
            .LANE_BITS (8 << w),
            .SIGNED_GT (w != 0)
        ) u_slice (
            .a        (in_a),
            .b        (in_b),
            .sum      (sum_v[w]),
            .eq_mask  (eq_v[w]),
            .gt_mask  (gt_v[w]),
            .gtu_mask (gtu_v[w])
        );
    end

    logic [N_HALF*CNT_W-1:0] counts;
    for (genvar i = 0; i < N_HALF; i++) begin : g_cnt
        assign counts[i*CNT_W +: CNT_W] = in_b[i*HALF_W +: CNT_W];
    end

    logic [D_W-1:0] shl_v;
    logic [D_W-1:0] rot_v;
    simd_hw_shifter #(.DATA_W(D_W), .HW(HALF_W)) u_shift (
        .a   (in_a),
        .cnt (counts),
        .shl (shl_v),
        .rot (rot_v)
    );

    logic slot_nonzero;
    logic slot_gt;
    simd_pslot_eval #(.PSLOT_W(PS_W)) u_pslot (
        .slot_a  (in_a[D_W-1 -: PS_W]),
        .slot_b  (in_b[D_W-1 -: PS_W]),
        .nonzero (slot_nonzero),
        .a_gt_b  (slot_gt)
    );

    logic [1:0] lane_idx;
    // map the lane code to a slice index; code 3 falls back to word
    always_comb begin
        case (in_lane)
            LN_BYTE: lane_idx = 2'd0;
            LN_HALF: lane_idx = 2'd1;
            default: lane_idx = 2'd2;
        endcase
    end

    logic [D_W-1:0] next_res;
    logic           is_write;
    // select the result for the opcode and flag whether it writes
    always_comb begin
        next_res = '0;
        is_write = 1'b1;
        case (in_op)
            OP_ADD:  next_res = sum_v[lane_idx];
            OP_AND:  next_res = in_a & in_b;
            OP_OR:   next_res = in_a | in_b;
            OP_XOR:  next_res = in_a ^ in_b;
            OP_NAND: next_res = ~(in_a & in_b);
            OP_NOR:  next_res = ~(in_a | in_b);
            OP_EQV:  next_res = ~(in_a ^ in_b);
            OP_SHLH: next_res = shl_v;
            OP_ROTH: next_res = rot_v;
            OP_CEQ:  next_res = eq_v[lane_idx];
            OP_CGT:  next_res = gt_v[lane_idx];
            OP_CLGT: next_res = gtu_v[lane_idx];
            default: is_write = 1'b0;
        endcase
    end

    logic accept;
    assign accept = in_valid && !halted;

    // result register, valid and taken pulses, and the sticky halt state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_taken  <= 1'b0;
            halted     <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= accept && is_write;
            out_taken <= accept && (in_op == OP_BRNZ) && slot_nonzero;
            if (accept && is_write) begin
                out_result <= next_res;
            end
            if (accept && (in_op == OP_HGT) && slot_gt) begin
                halted <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/simd_cmp_unit_chk.sv
`timescale 1ns/1ps
// Module: simd_cmp_unit_chk
// Temporal checks on the top module's ports, attached with bind.
// Assumes the word lane code and opcodes from simd_cmp_pkg.
module simd_cmp_unit_chk
    import simd_cmp_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [OP_W-1:0]     in_op,
    input logic [LANE_CW-1:0]  in_lane,
    input logic [PSLOT_W-1:0]  in_slot,
    input logic                out_valid,
    input logic [DATA_W-1:0]   out_result,
    input logic                out_taken,
    input logic                halted
);
    // true when every 32-bit lane is either all zeros or all ones
    function automatic logic words_are_masks(input logic [DATA_W-1:0] v);
        logic ok = 1'b1;
        for (int i = 0; i < DATA_W / 32; i++) begin
            if (v[i*32 +: 32] != '0 && v[i*32 +: 32] != '1) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R12
    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!out_valid && !out_taken)); // R12
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_result)); // R2
    AST_VALID_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R2
    AST_TAKEN_FROM_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_taken |-> $past(in_valid && in_op == OP_BRNZ && in_slot != '0)); // R10
    AST_HALT_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(in_valid && in_op == OP_HGT)); // R11
    AST_WORD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_lane == LN_WORD &&
            (in_op == OP_CEQ || in_op == OP_CGT || in_op == OP_CLGT)))
        |-> words_are_masks(out_result)); // R7
endmodule

bind simd_cmp_unit simd_cmp_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_lane    (in_lane),
    .in_slot    (in_a[simd_cmp_pkg::DATA_W-1 -: simd_cmp_pkg::PSLOT_W]),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_taken  (out_taken),
    .halted     (halted)
);

// File: tb/simd_cmp_unit_tb_top.sv
`timescale 1ns/1ps
// Directed bench for simd_cmp_unit: one task per scenario, each checking its results.
module simd_cmp_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [3:0]   in_op;
    logic [1:0]   in_lane;
    logic [127:0] in_a;
    logic [127:0] in_b;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_taken;
    logic         halted;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    simd_cmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_lane(in_lane), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_taken(out_taken), .halted(halted)
    );

    task automatic chk_vec(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // present one operation for one cycle; outputs are sampled at the following negedge
    task automatic issue(input logic [3:0] op, input logic [1:0] lane,
                         input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_lane = lane; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_lane = '0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1 out_valid", out_valid, 1'b0);
        chk_bit("R1 out_taken", out_taken, 1'b0);
        chk_bit("R1 halted", halted, 1'b0);
        chk_vec("R1 out_result", out_result, '0);
    endtask

    task automatic t_add();
        issue(4'd0, 2'd2, {32'hFFFFFFFF, 32'h1, 32'h7FFFFFFF, 32'h12345678},
                          {32'h1, 32'h2, 32'h1, 32'h11111111});
        chk_bit("R2 valid after write", out_valid, 1'b1);
        chk_vec("R3 word add", out_result, {32'h0, 32'h3, 32'h80000000, 32'h23456789});
        @(negedge clk);
        chk_bit("R2 valid drops", out_valid, 1'b0);
        chk_vec("R2 result held", out_result, {32'h0, 32'h3, 32'h80000000, 32'h23456789});
        issue(4'd0, 2'd0, {16{8'hFF}}, {16{8'h01}});
        chk_vec("R3 byte add", out_result, '0);
        issue(4'd0, 2'd1, {8{16'hFFFF}}, {8{16'h0002}});
        chk_vec("R3 half add", out_result, {8{16'h0001}});
        issue(4'd0, 2'd3, {4{32'hFFFFFFFF}}, {4{32'h00000002}});
        chk_vec("R3 lane code 3 as word", out_result, {4{32'h00000001}});
    endtask

    task automatic t_logic();
        logic [127:0] a = {4{32'hFF00F0F0}};
        logic [127:0] b = {4{32'h0F0F00FF}};
        logic [127:0] exp [1:6];
        exp[1] = {4{32'h0F0000F0}};
        exp[2] = {4{32'hFF0FF0FF}};
        exp[3] = {4{32'hF00FF00F}};
        exp[4] = {4{32'hF0FFFF0F}};
        exp[5] = {4{32'h00F00F00}};
        exp[6] = {4{32'h0FF00FF0}};
        for (int k = 1; k <= 6; k++) begin
            issue(k[3:0], 2'd0, a, b);
            chk_vec($sformatf("R4 logic op %0d", k), out_result, exp[k]);
        end
    endtask

    task automatic t_shift_rot();
        issue(4'd7, 2'd0, {8{16'h8421}},
              {16'd0, 16'd1, 16'd5, 16'd15, 16'd16, 16'd17, 16'd31, 16'd32});
        chk_vec("R5 halfword shift", out_result,
              {16'h8421, 16'h0842, 16'h8420, 16'h8000, 16'h0, 16'h0, 16'h0, 16'h8421});
        issue(4'd8, 2'd0, {8{16'h8421}},
              {16'd0, 16'd1, 16'd4, 16'd15, 16'd16, 16'd20, 16'd17, 16'd31});
        chk_vec("R6 halfword rotate", out_result,
              {16'h8421, 16'h0843, 16'h4218, 16'hC210, 16'h8421, 16'h4218, 16'h0843, 16'hC210});
    endtask

    task automatic t_compare();
        logic [127:0] ha = {16'h8000, 16'h0001, 16'h7FFF, 16'hFFFF, 16'h0, 16'h0, 16'h5, 16'h5};
        logic [127:0] hb = {16'h0001, 16'h8000, 16'hFFFF, 16'h7FFF, 16'h0, 16'h1, 16'h4, 16'h6};
        issue(4'd9, 2'd2, {32'd1, 32'd2, 32'd3, 32'd4}, {32'd1, 32'd5, 32'd3, 32'd0});
        chk_vec("R7 word equal", out_result, {32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h0});
        issue(4'd10, 2'd1, ha, hb);
        chk_vec("R8 signed half greater", out_result,
              {16'h0, 16'hFFFF, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h0});
        issue(4'd11, 2'd1, ha, hb);
        chk_vec("R9 unsigned half greater", out_result,
              {16'hFFFF, 16'h0, 16'h0, 16'hFFFF, 16'h0, 16'h0, 16'hFFFF, 16'h0});
        issue(4'd10, 2'd0, {8'h80, 8'h01, 112'h0}, {8'h01, 8'h80, 112'h0});
        chk_vec("R8 byte greater unsigned", out_result, {8'hFF, 120'h0});
        issue(4'd11, 2'd2, {32'h80000000, 96'h0}, {32'h1, 96'h0});
        chk_vec("R9 unsigned word greater", out_result, {32'hFFFFFFFF, 96'h0});
    endtask

    task automatic t_branch();
        logic [127:0] held = out_result;
        issue(4'd12, 2'd0, {32'h0, {3{32'hFFFFFFFF}}}, '0);
        chk_bit("R10 zero slot not taken", out_taken, 1'b0);
        issue(4'd12, 2'd0, {32'h00000100, 96'h0}, '0);
        chk_bit("R10 nonzero slot taken", out_taken, 1'b1);
        chk_bit("R10 no write", out_valid, 1'b0);
        chk_vec("R10 result unchanged", out_result, held);
        @(negedge clk);
        chk_bit("R10 single pulse", out_taken, 1'b0);
    endtask

    task automatic t_halt();
        issue(4'd0, 2'd2, {4{32'h1}}, {4{32'h1}});
        chk_vec("R2 pre-halt add", out_result, {4{32'h2}});
        issue(4'd13, 2'd0, {32'hFFFFFFFF, 96'h0}, {32'h1, 96'h0});
        chk_bit("R11 signed not greater", halted, 1'b0);
        chk_bit("R11 no write", out_valid, 1'b0);
        issue(4'd13, 2'd0, {32'd5, 96'h0}, {32'd3, {3{32'hFFFFFFFF}}});
        chk_bit("R11 halt entered", halted, 1'b1);
        issue(4'd0, 2'd2, {4{32'hFFFFFFFF}}, {4{32'h5}});
        chk_bit("R12 write blocked", out_valid, 1'b0);
        chk_vec("R12 result frozen", out_result, {4{32'h2}});
        issue(4'd12, 2'd0, {32'h1, 96'h0}, '0);
        chk_bit("R12 branch blocked", out_taken, 1'b0);
        chk_bit("R12 halt sticky", halted, 1'b1);
    endtask

    initial begin
        t_reset();
        t_add();
        t_logic();
        t_shift_rot();
        t_compare();
        t_branch();
        t_halt();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule